// File: doc/BRIEF.md
# Cache Access Policy Resolver

This block sits between address translation and the cache controllers. For every memory access it works out which caching mode applies (writethrough, copyback, inhibited-precise or inhibited-imprecise). It also works out the user page attribute bits and whether the target is write protected.

These results can come from three places:
- one of two transparent-translation windows;
- the translation cache, when a page descriptor is found there;
- the default fields of a translation-control register held inside the block.

From the resolved mode, the per-cache enable bits and an external cache-disable pin, the block then decides what the access does:
- whether the cache serves the access;
- whether memory is read or written;
- whether a line fill is requested;
- whether the access must fault or wait for a table walk.

All resolution is combinational within the access cycle. The only state is the translation-control default register. A one-cycle load strobe writes it, and reset returns it to known defaults. Snoop requests pass through untouched by the cache-disable pin. Tag arrays, data storage and bus signalling live elsewhere.

Top module: `cache_policy_resolver`

## Requirements
- R1: `res_mode` reports the resolved mode with encoding 00 = writethrough, 01 = copyback, 10 = inhibited-precise, 11 = inhibited-imprecise; only 00 and 01 are cachable.
- R2: When any transparent-translation window hits, it supplies mode, attribute bits and write protection, taking precedence over a translation-cache hit; window 0 takes precedence over window 1. Window i uses `tt_mode[2i+1:2i]` and `tt_upa[UPA_W*i +: UPA_W]`.
- R3: With paging enabled, no window hit and a translation-cache hit, the attributes come from the `atc_*` inputs.
- R4: With paging disabled and no window hit, the attributes come from the default register, and the translation-cache inputs have no effect.
- R5: After reset the default register holds paging off, writethrough, attribute bits 0 and writable. A cycle with `tc_wr` high loads the `tc_*_in` values, which take effect from the next cycle.
- R6: A cachable read that uses the cache and hits in the tags asserts `cache_rd_hit` with no memory read. A cachable read that misses asserts both `mem_rd` and `fill_req`.
- R7: An access in either inhibited mode asserts `cache_bypass` and goes to memory. It never asserts `fill_req`, `cache_rd_hit` or `cache_wr`.
- R8: While `ext_cache_off` is high, every access bypasses the cache. No fill, cache read or cache write is issued, and reads and writes go to memory. `snoop_go` still follows `snoop_req`.
- R9: A writethrough write always writes memory, and also writes the cache on a tag hit. A copyback write hit writes only the cache. A copyback write miss writes only memory.
- R10: An instruction fetch (`acc_fetch`=1) is always a read: `acc_write` is ignored, and writethrough and copyback give identical actions.
- R11: With paging enabled, no window hit and a translation-cache miss, `walk_req` is asserted. In that case `attr_valid` is low and no cache or memory action is issued.
- R12: A data write to a write-protected target asserts `acc_fault` and issues neither `mem_wr` nor `cache_wr`.
- R13: Fetches use the cache only when `icache_en` is high, and data accesses only when `dcache_en` is high. Otherwise the access bypasses the cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tc_wr | input | 1 | Load strobe for the default register |
| tc_pg_en_in | input | 1 | New paging-enable value |
| tc_mode_in | input | 2 | New default mode |
| tc_upa_in | input | UPA_W | New default attribute bits |
| tc_wp_in | input | 1 | New default write protection |
| tt_hit | input | NUM_TT | Per-window match |
| tt_mode | input | 2*NUM_TT | Per-window mode, packed |
| tt_upa | input | UPA_W*NUM_TT | Per-window attribute bits, packed |
| tt_wp | input | NUM_TT | Per-window write protection |
| atc_hit | input | 1 | Translation-cache hit |
| atc_mode | input | 2 | Descriptor mode |
| atc_upa | input | UPA_W | Descriptor attribute bits |
| atc_wp | input | 1 | Descriptor write protection |
| acc_valid | input | 1 | Access present this cycle |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_write | input | 1 | Access is a write (data only) |
| tag_hit | input | 1 | Tag match from the addressed cache |
| icache_en | input | 1 | Instruction cache enable |
| dcache_en | input | 1 | Data cache enable |
| ext_cache_off | input | 1 | External cache-disable pin, active high |
| snoop_req | input | 1 | Incoming snoop request |
| attr_valid | output | 1 | Resolved attributes are valid |
| res_mode | output | 2 | Resolved caching mode |
| res_upa | output | UPA_W | Resolved attribute bits |
| res_wp | output | 1 | Resolved write protection |
| walk_req | output | 1 | Table walk needed |
| cache_bypass | output | 1 | Access does not use the cache |
| cache_rd_hit | output | 1 | Read served by the cache |
| fill_req | output | 1 | Line fill requested |
| cache_wr | output | 1 | Cache write issued |
| mem_rd | output | 1 | Memory read issued |
| mem_wr | output | 1 | Memory write issued |
| acc_fault | output | 1 | Write-protection fault |
| snoop_go | output | 1 | Snoop passed to the cache |

## Verification
The action outputs are combinational, so a wrong priority or a wrong mode decode shows up at the ports in the same cycle as the access. Typical symptoms are a wrong `res_mode`/`res_upa`, a fill on an inhibited page, or a memory write on a protected one. The only stored state is the default register. A wrong reset value or load shows on the first access made with paging off and no window hit, one cycle after reset or after the load strobe.

// File: rtl/cpol_pkg.sv
// Shared types for the cache access policy resolver.
package cpol_pkg;
    typedef enum logic [1:0] {
        CM_WT     = 2'b00,
        CM_CB     = 2'b01,
        CM_INH_P  = 2'b10,
        CM_INH_IP = 2'b11
    } cmode_t;
endpackage

// File: rtl/cpol_tc_reg.sv
// Default translation-control register: paging enable plus default
// mode, attribute bits and write protection.
// Assumes: tc_wr is a single-cycle strobe; values apply from the next cycle.
module cpol_tc_reg #(
    parameter int UPA_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tc_wr,
    input  logic             pg_in,
    input  logic [1:0]       mode_in,
    input  logic [UPA_W-1:0] upa_in,
    input  logic             wp_in,
    output logic             pg_en,
    output logic [1:0]       dflt_mode,
    output logic [UPA_W-1:0] dflt_upa,
    output logic             dflt_wp
);
    import cpol_pkg::*;

    // Hold the defaults; reset to paging off, writethrough, zero, writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pg_en     <= 1'b0;
            dflt_mode <= CM_WT;
            dflt_upa  <= '0;
            dflt_wp   <= 1'b0;
        end else if (tc_wr) begin
            pg_en     <= pg_in;
            dflt_mode <= mode_in;
            dflt_upa  <= upa_in;
            dflt_wp   <= wp_in;
        end
    end

    assert_reset_dflt_R5: assert property (@(posedge clk)
        !rst_n |=> (!pg_en && dflt_mode == CM_WT && dflt_upa == '0 && !dflt_wp));

    assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tc_wr |=> (dflt_mode == $past(mode_in) && dflt_upa == $past(upa_in)
                   && dflt_wp == $past(wp_in) && pg_en == $past(pg_in)));
endmodule

// File: rtl/cpol_attr_sel.sv
// Attribute source selection: window 0 over higher windows, then the
// translation cache (paging on), else the defaults (paging off).
// Assumes: packed per-window fields, window i at slice i.
module cpol_attr_sel #(
    parameter int NUM_TT = 2,
    parameter int UPA_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_valid,
    input  logic [NUM_TT-1:0]       tt_hit,
    input  logic [2*NUM_TT-1:0]     tt_mode,
    input  logic [UPA_W*NUM_TT-1:0] tt_upa,
    input  logic [NUM_TT-1:0]       tt_wp,
    input  logic                    atc_hit,
    input  logic [1:0]              atc_mode,
    input  logic [UPA_W-1:0]        atc_upa,
    input  logic                    atc_wp,
    input  logic                    pg_en,
    input  logic [1:0]              dflt_mode,
    input  logic [UPA_W-1:0]        dflt_upa,
    input  logic                    dflt_wp,
    output logic                    attr_valid,
    output logic                    walk_req,
    output logic [1:0]              sel_mode,
    output logic [UPA_W-1:0]        sel_upa,
    output logic                    sel_wp
);
    logic [1:0]       w_mode [NUM_TT];
    logic [UPA_W-1:0] w_upa  [NUM_TT];
    logic             tt_any;

    // Split the packed window fields into per-window arrays.
    for (genvar i = 0; i < NUM_TT; i++) begin : g_win
        assign w_mode[i] = tt_mode[2*i +: 2];
        assign w_upa[i]  = tt_upa[UPA_W*i +: UPA_W];
    end

    assign tt_any = |tt_hit;

    // Pick the source: lowest hitting window, else descriptor, else defaults.
    always_comb begin
        sel_mode = dflt_mode;
        sel_upa  = dflt_upa;
        sel_wp   = dflt_wp;
        if (pg_en) begin
            sel_mode = atc_mode;
            sel_upa  = atc_upa;
            sel_wp   = atc_wp;
        end
        for (int i = NUM_TT - 1; i >= 0; i--) begin
            if (tt_hit[i]) begin
                sel_mode = w_mode[i];
                sel_upa  = w_upa[i];
                sel_wp   = tt_wp[i];
            end
        end
    end

    // Flag a walk when paging needs a descriptor that is not present.
    always_comb begin
        walk_req   = acc_valid && pg_en && !tt_any && !atc_hit;
        attr_valid = acc_valid && !walk_req;
    end

    assert_walk_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(walk_req && attr_valid));

    assert_tt0_prio_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tt_hit[0] |-> (sel_mode == tt_mode[1:0] && sel_wp == tt_wp[0]));
endmodule

// File: rtl/cpol_route.sv
// Access routing: chooses cache use, fills, memory traffic and faults
// from the resolved mode and the enable controls.
// Assumes: tag_hit is valid for the cache the access addresses.
module cpol_route (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       attr_valid,
    input  logic [1:0] mode,
    input  logic       wp,
    input  logic       acc_fetch,
    input  logic       acc_write,
    input  logic       tag_hit,
    input  logic       icache_en,
    input  logic       dcache_en,
    input  logic       ext_cache_off,
    output logic       cache_bypass,
    output logic       cache_rd_hit,
    output logic       fill_req,
    output logic       cache_wr,
    output logic       mem_rd,
    output logic       mem_wr,
    output logic       acc_fault
);
    import cpol_pkg::*;

    logic cachable, en_sel, use_c, is_wr, go, rd, wr, c_hit;

    // Decide whether the cache takes part in this access.
    always_comb begin
        cachable = (mode == CM_WT) || (mode == CM_CB);
        en_sel   = acc_fetch ? icache_en : dcache_en;
        use_c    = attr_valid && cachable && en_sel && !ext_cache_off;
        c_hit    = use_c && tag_hit;
        is_wr    = acc_write && !acc_fetch;
    end

    // Issue the actions for the access.
    always_comb begin
        acc_fault    = attr_valid && is_wr && wp;
        go           = attr_valid && !acc_fault;
        rd           = go && !is_wr;
        wr           = go && is_wr;
        cache_bypass = attr_valid && !use_c;
        cache_rd_hit = rd && c_hit;
        fill_req     = rd && use_c && !tag_hit;
        mem_rd       = rd && !c_hit;
        cache_wr     = wr && c_hit;
        mem_wr       = wr && !(c_hit && mode == CM_CB);
    end

    assert_fault_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fault |-> (!mem_wr && !cache_wr));

    assert_ext_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ext_cache_off |-> (!fill_req && !cache_rd_hit && !cache_wr));

    assert_inhibit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (attr_valid && mode[1]) |-> (cache_bypass && !fill_req && !cache_wr));

    assert_fill_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> (mem_rd && !cache_rd_hit && !mem_wr));

    assert_no_act_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !attr_valid |-> !(mem_rd || mem_wr || fill_req || cache_wr || cache_rd_hit));
endmodule

// File: rtl/cache_policy_resolver.sv
// Cache access policy resolver top: default register, attribute source
// selection and access routing. Snoops pass straight through.
// Assumes: all access inputs are stable for the cycle in which acc_valid is high.
module cache_policy_resolver #(
    parameter int NUM_TT = 2,
    parameter int UPA_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tc_wr,
    input  logic                    tc_pg_en_in,
    input  logic [1:0]              tc_mode_in,
    input  logic [UPA_W-1:0]        tc_upa_in,
    input  logic                    tc_wp_in,
    input  logic [NUM_TT-1:0]       tt_hit,
    input  logic [2*NUM_TT-1:0]     tt_mode,
    input  logic [UPA_W*NUM_TT-1:0] tt_upa,
    input  logic [NUM_TT-1:0]       tt_wp,
    input  logic                    atc_hit,
    input  logic [1:0]              atc_mode,
    input  logic [UPA_W-1:0]        atc_upa,
    input  logic                    atc_wp,
    input  logic                    acc_valid,
    input  logic                    acc_fetch,
    input  logic                    acc_write,
    input  logic                    tag_hit,
    input  logic                    icache_en,
    input  logic                    dcache_en,
    input  logic                    ext_cache_off,
    input  logic                    snoop_req,
    output logic                    attr_valid,
    output logic [1:0]              res_mode,
    output logic [UPA_W-1:0]        res_upa,
    output logic                    res_wp,
    output logic                    walk_req,
    output logic                    cache_bypass,
    output logic                    cache_rd_hit,
    output logic                    fill_req,
    output logic                    cache_wr,
    output logic                    mem_rd,
    output logic                    mem_wr,
    output logic                    acc_fault,
    output logic                    snoop_go
);
    logic             pg_en, dflt_wp;
    logic [1:0]       dflt_mode;
    logic [UPA_W-1:0] dflt_upa;

    cpol_tc_reg #(.UPA_W(UPA_W)) u_tc (
        .clk(clk), .rst_n(rst_n), .tc_wr(tc_wr), .pg_in(tc_pg_en_in),
        .mode_in(tc_mode_in), .upa_in(tc_upa_in), .wp_in(tc_wp_in),
        .pg_en(pg_en), .dflt_mode(dflt_mode), .dflt_upa(dflt_upa),
        .dflt_wp(dflt_wp)
    );

    cpol_attr_sel #(.NUM_TT(NUM_TT), .UPA_W(UPA_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid),
        .tt_hit(tt_hit), .tt_mode(tt_mode), .tt_upa(tt_upa), .tt_wp(tt_wp),
        .atc_hit(atc_hit), .atc_mode(atc_mode), .atc_upa(atc_upa),
        .atc_wp(atc_wp), .pg_en(pg_en), .dflt_mode(dflt_mode),
        .dflt_upa(dflt_upa), .dflt_wp(dflt_wp), .attr_valid(attr_valid),
        .walk_req(walk_req), .sel_mode(res_mode), .sel_upa(res_upa),
        .sel_wp(res_wp)
    );

    cpol_route u_route (
        .clk(clk), .rst_n(rst_n), .attr_valid(attr_valid), .mode(res_mode),
        .wp(res_wp), .acc_fetch(acc_fetch), .acc_write(acc_write),
        .tag_hit(tag_hit), .icache_en(icache_en), .dcache_en(dcache_en),
        .ext_cache_off(ext_cache_off), .cache_bypass(cache_bypass),
        .cache_rd_hit(cache_rd_hit), .fill_req(fill_req), .cache_wr(cache_wr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .acc_fault(acc_fault)
    );

    // Snoops are never gated by the cache-disable pin.
    assign snoop_go = snoop_req;
endmodule

// File: tb/cache_policy_resolver_tb.sv
module cache_policy_resolver_tb;
    localparam int NUM_TT = 2;
    localparam int UPA_W  = 2;

    logic clk = 1'b0;
    logic rst_n;
    logic tc_wr, tc_pg_en_in, tc_wp_in;
    logic [1:0] tc_mode_in;
    logic [UPA_W-1:0] tc_upa_in;
    logic [NUM_TT-1:0] tt_hit, tt_wp;
    logic [2*NUM_TT-1:0] tt_mode;
    logic [UPA_W*NUM_TT-1:0] tt_upa;
    logic atc_hit, atc_wp;
    logic [1:0] atc_mode;
    logic [UPA_W-1:0] atc_upa;
    logic acc_valid, acc_fetch, acc_write, tag_hit;
    logic icache_en, dcache_en, ext_cache_off, snoop_req;
    logic attr_valid, res_wp, walk_req, cache_bypass, cache_rd_hit;
    logic fill_req, cache_wr, mem_rd, mem_wr, acc_fault, snoop_go;
    logic [1:0] res_mode;
    logic [UPA_W-1:0] res_upa;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cache_policy_resolver #(.NUM_TT(NUM_TT), .UPA_W(UPA_W)) u_dut (.*);

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        tc_wr = 0; tc_pg_en_in = 0; tc_mode_in = 0; tc_upa_in = 0; tc_wp_in = 0;
        tt_hit = 0; tt_mode = 0; tt_upa = 0; tt_wp = 0;
        atc_hit = 0; atc_mode = 0; atc_upa = 0; atc_wp = 0;
        acc_valid = 0; acc_fetch = 0; acc_write = 0; tag_hit = 0;
        icache_en = 1; dcache_en = 1; ext_cache_off = 0; snoop_req = 0;
    endtask

    // Load the default register: strobe over one rising edge.
    task automatic load_tc(logic pg, logic [1:0] m, logic [1:0] u, logic w);
        @(negedge clk);
        tc_wr = 1; tc_pg_en_in = pg; tc_mode_in = m; tc_upa_in = u; tc_wp_in = w;
        @(negedge clk);
        tc_wr = 0;
    endtask

    // Present an access and let the combinational outputs settle.
    task automatic access(logic fetch, logic wr, logic hit);
        @(negedge clk);
        acc_valid = 1; acc_fetch = fetch; acc_write = wr; tag_hit = hit;
        #1;
    endtask

    task automatic t_reset();
        idle();
        access(0, 0, 0);
        chk("R5", "attr_valid", attr_valid, 1);
        chk("R5", "mode WT", res_mode, 0);
        chk("R5", "upa", res_upa, 0);
        chk("R5", "wp", res_wp, 0);
        chk("R6", "fill on miss", fill_req, 1);
        chk("R6", "mem_rd on miss", mem_rd, 1);
    endtask

    task automatic t_defaults();
        idle();
        load_tc(0, 2'b01, 2'b11, 0);
        atc_hit = 1; atc_mode = 2'b10; atc_upa = 2'b01;
        access(0, 0, 1);
        chk("R5", "loaded mode", res_mode, 1);
        chk("R4", "upa from defaults", res_upa, 3);
        chk("R4", "atc ignored, cache hit", cache_rd_hit, 1);
        chk("R6", "no mem_rd on hit", mem_rd, 0);
    endtask

    task automatic t_atc();
        idle();
        load_tc(1, 2'b00, 2'b00, 0);
        atc_hit = 1; atc_mode = 2'b01; atc_upa = 2'b10;
        access(0, 0, 1);
        chk("R3", "atc mode", res_mode, 1);
        chk("R3", "atc upa", res_upa, 2);
        chk("R3", "hit served", cache_rd_hit, 1);
    endtask

    task automatic t_tt_prio();
        idle();
        atc_hit = 1; atc_mode = 2'b01; atc_upa = 2'b10;
        tt_hit = 2'b10; tt_mode = 4'b10_00; tt_upa = 4'b01_00;
        access(0, 0, 1);
        chk("R2", "tt1 over atc mode", res_mode, 2);
        chk("R2", "tt1 upa", res_upa, 1);
        chk("R7", "bypass", cache_bypass, 1);
        chk("R7", "mem_rd", mem_rd, 1);
        chk("R7", "no fill", fill_req, 0);
        chk("R7", "no cache read", cache_rd_hit, 0);
        tt_hit = 2'b11; tt_mode = 4'b10_00; tt_upa = 4'b01_11; #1;
        chk("R2", "tt0 over tt1 mode", res_mode, 0);
        chk("R2", "tt0 upa", res_upa, 3);
    endtask

    task automatic t_imprecise();
        idle();
        tt_hit = 2'b01; tt_mode = 4'b00_11;
        access(0, 1, 1);
        chk("R1", "imprecise code", res_mode, 3);
        chk("R7", "bypass", cache_bypass, 1);
        chk("R7", "mem_wr", mem_wr, 1);
        chk("R7", "no cache_wr", cache_wr, 0);
    endtask

    task automatic t_walk();
        idle();
        access(0, 0, 0);
        chk("R11", "walk_req", walk_req, 1);
        chk("R11", "attr_valid", attr_valid, 0);
        chk("R11", "no mem_rd", mem_rd, 0);
        chk("R11", "no fill", fill_req, 0);
    endtask

    task automatic t_writes();
        idle();
        atc_hit = 1; atc_mode = 2'b00;
        access(0, 1, 1);
        chk("R9", "WT hit mem_wr", mem_wr, 1);
        chk("R9", "WT hit cache_wr", cache_wr, 1);
        atc_mode = 2'b01; #1;
        chk("R9", "CB hit mem_wr", mem_wr, 0);
        chk("R9", "CB hit cache_wr", cache_wr, 1);
        tag_hit = 0; #1;
        chk("R9", "CB miss mem_wr", mem_wr, 1);
        chk("R9", "CB miss cache_wr", cache_wr, 0);
    endtask

    task automatic t_fault();
        idle();
        atc_hit = 1; atc_mode = 2'b00; atc_wp = 1;
        access(0, 1, 1);
        chk("R12", "fault", acc_fault, 1);
        chk("R12", "no mem_wr", mem_wr, 0);
        chk("R12", "no cache_wr", cache_wr, 0);
        acc_write = 0; tag_hit = 0; #1;
        chk("R12", "read no fault", acc_fault, 0);
        chk("R12", "read mem_rd", mem_rd, 1);
    endtask

    task automatic t_ext_off();
        idle();
        atc_hit = 1; ext_cache_off = 1; snoop_req = 1;
        access(0, 0, 1);
        chk("R8", "bypass", cache_bypass, 1);
        chk("R8", "no cache read", cache_rd_hit, 0);
        chk("R8", "mem_rd", mem_rd, 1);
        chk("R8", "no fill", fill_req, 0);
        chk("R8", "snoop_go", snoop_go, 1);
        acc_write = 1; #1;
        chk("R8", "no cache_wr", cache_wr, 0);
        chk("R8", "mem_wr", mem_wr, 1);
    endtask

    task automatic t_fetch();
        idle();
        atc_hit = 1; atc_mode = 2'b01;
        access(1, 1, 0);
        chk("R10", "CB fetch fill", fill_req, 1);
        chk("R10", "CB fetch no mem_wr", mem_wr, 0);
        atc_mode = 2'b00; #1;
        chk("R10", "WT fetch fill", fill_req, 1);
        chk("R10", "WT fetch mem_rd", mem_rd, 1);
        icache_en = 0; #1;
        chk("R13", "icache off bypass", cache_bypass, 1);
        chk("R13", "icache off no fill", fill_req, 0);
        acc_fetch = 0; acc_write = 0; icache_en = 1; dcache_en = 0; #1;
        chk("R13", "dcache off bypass", cache_bypass, 1);
        dcache_en = 1; #1;
        chk("R13", "dcache on uses cache", cache_bypass, 0);
    endtask

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_defaults();
        t_atc();
        t_tt_prio();
        t_imprecise();
        t_walk();
        t_writes();
        t_fault();
        t_ext_off();
        t_fetch();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule